// File: doc/BRIEF.md
# SIMD Binary-Image Cell Array

A parameterized grid of identical processing cells, 32 rows by 32 columns by default. Every cell executes the same broadcast instruction in a given cycle. Each cell keeps four binary pixels, one from each of four stored images. It also has two hardwired constant sources, a two-input gate that can be programmed to any Boolean function, and a pair of selectors. The selectors choose which stored image or constant drives the external analog core as the network input U and as the initial state X(0).

Images enter through a column-serial load port and leave through a column-serial download port with a valid strobe. The analog core is not part of this block. Its binary settled output enters as one bit per cell and is written into the store with a capture instruction. Constant +1 is represented as logic 1 and -1 as logic 0.

An instruction is taken when `instr_valid_i` and `ready_o` are both high. Load and download keep `ready_o` low while their column sequence runs.

Top module: `simd_cell_array`

## Requirements
- R1: After reset every stored bit is 0, `ready_o` is 1, `dl_valid_o` is 0, and `u_o`/`x0_o` both show store slot 0 (all zeros).
- R2: Source selector codes: 0 to 3 pick store slot 0 to 3, 4 gives constant 1 (+1), 5 gives constant 0 (-1), and 6 and 7 read as 0.
- R3: Opcode 1 (move) copies source A into store slot `dst_i` of every cell at the accepting edge. `ready_o` stays high.
- R4: Opcode 2 (logic) writes `truth_i[2*A+B]` into slot `dst_i` of every cell. A and B are the bits chosen by `src_a_i` and `src_b_i`.
- R5: Opcode 3 (load) writes `load_col_i` into slot `dst_i`. Column 0 is taken on the accepting edge and columns 1 to COLS-1 on the following edges, with bit r going to row r. `ready_o` is low from the edge after acceptance until the last column has been written.
- R6: Opcode 4 (capture) writes `core_i[r*COLS+c]` into slot `dst_i` of cell (r,c) at the accepting edge.
- R7: Opcode 5 (select) latches `src_a_i` as the U selector and `src_b_i` as the X(0) selector. `u_o[r*COLS+c]` and `x0_o[r*COLS+c]` show the selected source of cell (r,c) and track later store writes without reselection.
- R8: Opcode 6 (download) raises `dl_valid_o` for COLS cycles starting the cycle after acceptance. In the k-th valid cycle `dl_col_o[r]` is the `src_a_i` source of cell (r,k), and `ready_o` is low throughout.
- R9: Opcode 0, reserved opcode 7, and any instruction presented while `ready_o` is low change no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction present |
| opcode_i | input | 3 | Operation code |
| src_a_i | input | 3 | Source A selector |
| src_b_i | input | 3 | Source B selector |
| dst_i | input | 2 | Destination store slot |
| truth_i | input | 4 | Gate truth table, indexed {A,B} |
| ready_o | output | 1 | Instruction can be accepted |
| load_col_i | input | ROWS | Column data for load |
| core_i | input | ROWS*COLS | Analog core output bit per cell |
| u_o | output | ROWS*COLS | Selected U source per cell |
| x0_o | output | ROWS*COLS | Selected X(0) source per cell |
| dl_col_o | output | ROWS | Downloaded column |
| dl_valid_o | output | 1 | Download column valid |

## Verification
A corrupted store bit becomes visible one cycle after a select that names its slot, on the matching bit of `u_o` or `x0_o`. It also appears in the corresponding column of a download. A wrong column counter shows up as data shifted between columns on `dl_col_o`, or as a `ready_o` edge one cycle early or late at the end of a load or download. Gate decoding errors appear on the first logic instruction that exercises the affected truth-table entry. Mixed random instruction streams are therefore interleaved with full readbacks of all four slots.

// File: rtl/simd_array_pkg.sv
package simd_array_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_MOVE    = 3'd1,
    OP_LOGIC   = 3'd2,
    OP_LOAD    = 3'd3,
    OP_CAPTURE = 3'd4,
    OP_SELECT  = 3'd5,
    OP_READ    = 3'd6,
    OP_RSVD    = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_MOVE,
    WR_LOGIC,
    WR_LOAD,
    WR_CAPTURE
  } wr_kind_e;

  typedef struct packed {
    wr_kind_e   kind;
    logic [2:0] src_a;
    logic [2:0] src_b;
    logic [1:0] dst;
    logic [3:0] truth;
  } wr_ctrl_t;

  typedef struct packed {
    logic [2:0] u_sel;
    logic [2:0] x0_sel;
    logic [2:0] dl_sel;
  } view_sel_t;

  // codes 0..3 store slot, 4 -> +1 (1), 5 -> -1 (0), 6/7 -> 0
  function automatic logic pick_src(logic [3:0] store, logic [2:0] sel);
    logic v;
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: v = store[sel[1:0]];
      3'd4:                   v = 1'b1;
      default:                v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/simd_cell.sv
module simd_cell
  import simd_array_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wr_ctrl_t  wr_i,
  input  view_sel_t view_i,
  input  logic      col_hit_i,
  input  logic      load_bit_i,
  input  logic      core_bit_i,
  output logic      u_o,
  output logic      x0_o,
  output logic      dl_o
);

  logic [3:0] store_q;
  logic       a_bit, b_bit, gate_bit;

  assign a_bit    = pick_src(store_q, wr_i.src_a);
  assign b_bit    = pick_src(store_q, wr_i.src_b);
  assign gate_bit = wr_i.truth[{a_bit, b_bit}];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else begin
      case (wr_i.kind)
        WR_MOVE:    store_q[wr_i.dst] <= a_bit;
        WR_LOGIC:   store_q[wr_i.dst] <= gate_bit;
        WR_LOAD:    if (col_hit_i) store_q[wr_i.dst] <= load_bit_i;
        WR_CAPTURE: store_q[wr_i.dst] <= core_bit_i;
        default:    ;
      endcase
    end
  end

  assign u_o  = pick_src(store_q, view_i.u_sel);
  assign x0_o = pick_src(store_q, view_i.x0_sel);
  assign dl_o = pick_src(store_q, view_i.dl_sel);

endmodule

// File: rtl/simd_seq.sv
module simd_seq
  import simd_array_pkg::*;
#(
  parameter int COLS = 32,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [2:0]    opcode_i,
  input  logic [2:0]    src_a_i,
  input  logic [2:0]    src_b_i,
  input  logic [1:0]    dst_i,
  input  logic [3:0]    truth_i,
  output logic          ready_o,
  output wr_ctrl_t      wr_o,
  output view_sel_t     view_o,
  output logic [CW-1:0] col_idx_o,
  output logic          dl_valid_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_READ} seq_state_e;

  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    ld_dst_q;
  view_sel_t     view_q;
  logic          accept;
  opcode_e       op;

  assign op     = opcode_e'(opcode_i);
  assign accept = instr_valid_i && (state_q == ST_IDLE);

  always_comb begin
    wr_o       = '0;
    wr_o.kind  = WR_NONE;
    wr_o.src_a = src_a_i;
    wr_o.src_b = src_b_i;
    wr_o.dst   = dst_i;
    wr_o.truth = truth_i;
    if (accept) begin
      case (op)
        OP_MOVE:    wr_o.kind = WR_MOVE;
        OP_LOGIC:   wr_o.kind = WR_LOGIC;
        OP_LOAD:    wr_o.kind = WR_LOAD;
        OP_CAPTURE: wr_o.kind = WR_CAPTURE;
        default:    wr_o.kind = WR_NONE;
      endcase
    end else if (state_q == ST_LOAD) begin
      wr_o.kind = WR_LOAD;
      wr_o.dst  = ld_dst_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ld_dst_q <= '0;
      view_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            case (op)
              OP_SELECT: begin
                view_q.u_sel  <= src_a_i;
                view_q.x0_sel <= src_b_i;
              end
              OP_LOAD: begin
                if (COLS > 1) begin
                  state_q  <= ST_LOAD;
                  cnt_q    <= CW'(1);
                  ld_dst_q <= dst_i;
                end
              end
              OP_READ: begin
                view_q.dl_sel <= src_a_i;
                state_q       <= ST_READ;
                cnt_q         <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_LOAD, ST_READ: begin
          if (cnt_q == LAST_COL) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign dl_valid_o = (state_q == ST_READ);
  assign col_idx_o  = (state_q == ST_IDLE) ? '0 : cnt_q;
  assign view_o     = view_q;

endmodule

// File: rtl/simd_cell_array.sv
module simd_cell_array
  import simd_array_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int NCELL = ROWS * COLS,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [2:0]       opcode_i,
  input  logic [2:0]       src_a_i,
  input  logic [2:0]       src_b_i,
  input  logic [1:0]       dst_i,
  input  logic [3:0]       truth_i,
  output logic             ready_o,
  input  logic [ROWS-1:0]  load_col_i,
  input  logic [NCELL-1:0] core_i,
  output logic [NCELL-1:0] u_o,
  output logic [NCELL-1:0] x0_o,
  output logic [ROWS-1:0]  dl_col_o,
  output logic             dl_valid_o
);

  wr_ctrl_t      wr;
  view_sel_t     view;
  logic [CW-1:0] col_idx;
  logic          dl_run;
  logic [COLS-1:0] dl_rows [ROWS];

  simd_seq #(.COLS(COLS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .instr_valid_i(instr_valid_i),
    .opcode_i     (opcode_i),
    .src_a_i      (src_a_i),
    .src_b_i      (src_b_i),
    .dst_i        (dst_i),
    .truth_i      (truth_i),
    .ready_o      (ready_o),
    .wr_o         (wr),
    .view_o       (view),
    .col_idx_o    (col_idx),
    .dl_valid_o   (dl_run)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic col_hit;
      assign col_hit = (col_idx == CW'(c));
      simd_cell u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr),
        .view_i    (view),
        .col_hit_i (col_hit),
        .load_bit_i(load_col_i[r]),
        .core_bit_i(core_i[IDX]),
        .u_o       (u_o[IDX]),
        .x0_o      (x0_o[IDX]),
        .dl_o      (dl_rows[r][c])
      );
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      dl_col_o[r] = dl_run & dl_rows[r][col_idx];
    end
  end

  assign dl_valid_o = dl_run;

endmodule

// File: rtl/simd_array_checks.sv
module simd_array_checks #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int NCELL = ROWS * COLS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [2:0]       opcode_i,
  input logic [2:0]       src_a_i,
  input logic [2:0]       src_b_i,
  input logic             ready_o,
  input logic [NCELL-1:0] u_o,
  input logic [NCELL-1:0] x0_o,
  input logic             dl_valid_o
);

  logic acc;
  assign acc = instr_valid_i && ready_o;

  assert_read_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == 3'd6) |=> dl_valid_o);

  assert_read_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> !ready_o);

  if (COLS > 1) begin : g_load_busy
    assert_load_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && opcode_i == 3'd3) |=> (!ready_o && !dl_valid_o));
  end

  assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (opcode_i inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd7})) |=> (ready_o && !dl_valid_o));

  assert_const_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == 3'd5 && src_a_i == 3'd4) |=> (&u_o));

  assert_const_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == 3'd5 && src_b_i inside {3'd5, 3'd6, 3'd7}) |=> (x0_o == '0));

endmodule

bind simd_cell_array simd_array_checks #(.ROWS(ROWS), .COLS(COLS)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .opcode_i     (opcode_i),
  .src_a_i      (src_a_i),
  .src_b_i      (src_b_i),
  .ready_o      (ready_o),
  .u_o          (u_o),
  .x0_o         (x0_o),
  .dl_valid_o   (dl_valid_o)
);

// File: tb/simd_cell_array_test.sv
`timescale 1ns/1ps
module simd_cell_array_test;
  localparam int ROWS = 32;
  localparam int COLS = 32;
  localparam int N    = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            instr_valid_i = 1'b0;
  logic [2:0]      opcode_i = '0, src_a_i = '0, src_b_i = '0;
  logic [1:0]      dst_i = '0;
  logic [3:0]      truth_i = '0;
  logic            ready_o;
  logic [ROWS-1:0] load_col_i = '0;
  logic [N-1:0]    core_i = '0;
  logic [N-1:0]    u_o, x0_o;
  logic [ROWS-1:0] dl_col_o;
  logic            dl_valid_o;

  always #2.5 clk = ~clk;

  simd_cell_array #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .opcode_i(opcode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i), .truth_i(truth_i),
    .ready_o(ready_o), .load_col_i(load_col_i), .core_i(core_i), .u_o(u_o),
    .x0_o(x0_o), .dl_col_o(dl_col_o), .dl_valid_o(dl_valid_o)
  );

  logic [3:0] bm [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic src_bit(int i, logic [2:0] sel);
    if (sel < 3'd4) return bm[i][sel[1:0]];
    return (sel == 3'd4);
  endfunction

  function automatic logic [N-1:0] exp_src(logic [2:0] sel);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = src_bit(i, sel);
    return v;
  endfunction

  task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [1:0] d, logic [3:0] t);
    @(negedge clk);
    instr_valid_i = 1'b1; opcode_i = op; src_a_i = a; src_b_i = b; dst_i = d; truth_i = t;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic do_select(logic [2:0] a, logic [2:0] b, string tag);
    issue(3'd5, a, b, 2'd0, 4'd0);
    chk_vec({tag, " u"}, u_o, exp_src(a));
    chk_vec({tag, " x0"}, x0_o, exp_src(b));
  endtask

  task automatic verify_all(string tag);
    for (int s = 0; s < 4; s++) begin
      logic [2:0] b;
      b = 3'($urandom % 8);
      do_select(3'(s), b, tag);
    end
  endtask

  task automatic do_move(logic [2:0] a, logic [1:0] d);
    issue(3'd1, a, 3'd0, d, 4'd0);
    chk_val("R3 ready after move", 32'(ready_o), 32'd1);
    for (int i = 0; i < N; i++) bm[i][d] = src_bit(i, a);
  endtask

  task automatic do_logic(logic [2:0] a, logic [2:0] b, logic [1:0] d, logic [3:0] t);
    logic [N-1:0] nv;
    for (int i = 0; i < N; i++) nv[i] = t[{src_bit(i, a), src_bit(i, b)}];
    issue(3'd2, a, b, d, t);
    for (int i = 0; i < N; i++) bm[i][d] = nv[i];
  endtask

  task automatic do_capture(logic [1:0] d);
    for (int k = 0; k < N; k += 32) core_i[k +: 32] = $urandom;
    issue(3'd4, 3'd0, 3'd0, d, 4'd0);
    for (int i = 0; i < N; i++) bm[i][d] = core_i[i];
  endtask

  task automatic do_load(logic [1:0] d, bit junk);
    logic [ROWS-1:0] cols [COLS];
    for (int c = 0; c < COLS; c++) cols[c] = ROWS'($urandom);
    @(negedge clk);
    instr_valid_i = 1'b1; opcode_i = 3'd3; dst_i = d; load_col_i = cols[0];
    for (int c = 1; c < COLS; c++) begin
      @(negedge clk);
      if (c == 1) chk_val("R5 ready low during load", 32'(ready_o), 32'd0);
      load_col_i = cols[c];
      if (junk) begin // R9: busy-time instruction must be dropped
        instr_valid_i = 1'b1; opcode_i = 3'd1; src_a_i = 3'd4; dst_i = d + 2'd1;
      end else begin
        instr_valid_i = 1'b0;
      end
    end
    @(negedge clk);
    instr_valid_i = 1'b0;
    chk_val("R5 ready back after load", 32'(ready_o), 32'd1);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) bm[r*COLS + c][d] = cols[c][r];
  endtask

  task automatic do_read(logic [2:0] s);
    logic [ROWS-1:0] ec;
    @(negedge clk);
    instr_valid_i = 1'b1; opcode_i = 3'd6; src_a_i = s;
    @(negedge clk);
    instr_valid_i = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) ec[r] = src_bit(r*COLS + c, s);
      chk_val("R8 dl_valid", 32'({dl_valid_o, ready_o}), 32'b10);
      chk_val($sformatf("R8 column %0d src %0d", c, s), 32'(dl_col_o), 32'(ec));
      @(negedge clk);
    end
    chk_val("R8 download end", 32'({dl_valid_o, ready_o}), 32'b01);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) bm[i] = '0;
    repeat (3) @(negedge clk);
    chk_val("R1 ready/valid in reset", 32'({ready_o, dl_valid_o}), 32'b10);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_val("R1 ready/valid after reset", 32'({ready_o, dl_valid_o}), 32'b10);
    chk_vec("R1 u reset", u_o, '0);
    chk_vec("R1 x0 reset", x0_o, '0);
    verify_all("R1 store cleared");

    do_select(3'd4, 3'd5, "R2 constants");
    do_select(3'd6, 3'd7, "R2 reserved codes");

    do_load(2'd0, 1'b0);
    do_load(2'd1, 1'b1);
    do_load(2'd2, 1'b0);
    do_load(2'd3, 1'b1);
    verify_all("R5 R9 loaded images");

    do_read(3'd0); do_read(3'd3); do_read(3'd4); do_read(3'd5);

    do_move(3'd2, 2'd0);
    do_move(3'd5, 2'd3);
    verify_all("R3 move");
    do_move(3'd4, 2'd1);
    do_move(3'd3, 2'd2);
    verify_all("R3 move const");

    do_load(2'd0, 1'b0);
    do_load(2'd1, 1'b0);
    for (int t = 0; t < 16; t++) begin
      do_logic(3'd0, 3'd1, 2'(2 + (t % 2)), 4'(t));
      do_select(3'(2 + (t % 2)), 3'd0, $sformatf("R4 truth %h", t));
    end

    do_capture(2'd2);
    do_capture(2'd0);
    verify_all("R6 capture");

    // R7: view tracks store writes without reselect
    do_select(3'd1, 3'd2, "R7 select");
    do_move(3'd4, 2'd1);
    chk_vec("R7 u tracks store", u_o, exp_src(3'd1));
    do_logic(3'd1, 3'd0, 2'd2, 4'b0110);
    chk_vec("R7 x0 tracks store", x0_o, exp_src(3'd2));

    issue(3'd0, 3'd4, 3'd4, 2'd0, 4'hF);
    issue(3'd7, 3'd4, 3'd4, 2'd1, 4'hF);
    verify_all("R9 nop/reserved");

    for (int k = 0; k < 160; k++) begin
      int pick;
      logic [2:0] a, b;
      logic [1:0] d;
      pick = int'($urandom % 6);
      a = 3'($urandom % 8); b = 3'($urandom % 8); d = 2'($urandom);
      case (pick)
        0: do_move(a, d);
        1, 2: do_logic(a, b, d, 4'($urandom));
        3: do_capture(d);
        4: issue(3'($urandom % 2 == 0 ? 0 : 7), a, b, d, 4'($urandom));
        default: do_select(a, b, "R7 random select");
      endcase
      if (k % 40 == 39) begin
        verify_all("R3 R4 R6 random mix");
        do_read(3'($urandom % 4));
      end
    end
    verify_all("R9 final");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R5 R8 act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule